// File: doc/BRIEF.md
# Byte-Framed Chainable SPI Command Slave

This block is the serial control port of a motor-driver-style device. A host reaches it over a four-wire SPI link in mode 3: the clock idles high, and input is captured on the rising edge. Data travels in 8-bit units, most significant bit first. While chip select is held low, an 8-bit shift register acts only as a one-byte delay line between MOSI and MISO. Several devices can therefore be wired output-to-input and share one chip select. Each device ends up holding its own byte when the select is released.

The byte left in the shift register is interpreted only when chip select rises. That byte may be a command, or a data byte that belongs to an earlier parameter write. The byte to be returned is then written back into the shift register, and it leaves on MISO during the next select-low period. The commands are NOP, read status, read parameter and write parameter. Six parameter registers of one, two or three bytes are visible on an output bus. The whole design runs on a fast system clock that oversamples SCK and CS.

Top module: `spi_chain_slave`

## Requirements
- R1: Within a select-low period, MOSI is captured on each rising SCK edge, MSB first. MISO takes its next bit after each falling SCK edge.
- R2: A frame that is a multiple of 8 bits long repeats on MISO the bytes given on MOSI, one byte later, with no change. Its first output byte is the byte loaded at the previous decode. Only the last byte of the frame is interpreted.
- R3: Decoding happens only when chip select rises after a non-zero multiple of 8 clocks. The reply byte is in the shift register within 3 clock cycles, so a high time of 4 system clocks between frames is sufficient.
- R4: From the second clock cycle that chip select is high, MISO stays low.
- R5: Byte 00h is NOP. It loads the next pending reply byte, or 00h when none is pending.
- R6: Byte D0h loads DEV_ID (default 5Ah) at once. It queues one more byte, {6'b0, bad_addr at bit 1, bad_cmd at bit 0}. Reading the status clears both flags.
- R7: Byte 001aaaaa, with a in 1..NUM_REGS, returns parameter a MSB first. The first byte is loaded at once, and the remaining bytes go out on following NOPs. Parameter a is ((a+2) mod 3)+1 bytes wide.
- R8: Byte 000aaaaa, with a in 1..NUM_REGS, treats the next ((a+2) mod 3)+1 whole frames as data bytes, MSB first. Those bytes are not decoded as commands. The parameter, seen on param_regs[(a-1)*24 +: 24] and right-aligned, is written after the last data byte.
- R9: When chip select rises after a bit count that is zero or not a multiple of 8, the frame is discarded. The decoder state is unchanged, and the shift register gets back the byte it held before the frame.
- R10: Any decoded command other than NOP drops every reply byte still pending.
- R11: A get or set byte with address 0 or an address above NUM_REGS sets bad_addr. Any other unknown byte sets bad_cmd. In both cases 00h is loaded.
- R12: After reset, all parameters are zero, both flags are clear, the shift register holds 00h and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| param_regs | output | NUM_REGS*24 | Parameter values, 24 bits per register, right-aligned |

## Verification
The hardest states to reach from the pins are the ones where a frame does not end on a byte boundary in the middle of a multi-byte exchange. One case is a partial frame that arrives while a parameter read still has bytes pending. Another is a frame of 12 clocks that follows a whole byte. The bench drives the serial lines bit by bit and can raise chip select after any bit count, so it can place these partial frames between a read command and its NOP frames. Multi-byte frames with a command in the last position check the delay-line path together with decoding.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int MAX_BYTES = 3;
  localparam int VAL_W     = BYTE_W * MAX_BYTES;

  localparam logic [BYTE_W-1:0] OP_NOP    = 8'h00;
  localparam logic [BYTE_W-1:0] OP_STATUS = 8'hD0;
  localparam logic [2:0]        GRP_SET   = 3'b000;
  localparam logic [2:0]        GRP_GET   = 3'b001;

  typedef enum logic {DEC_CMD, DEC_DATA} dec_state_e;

  // Width in bytes of parameter a (a >= 1): 1,2,3,1,2,3,...
  function automatic logic [1:0] reg_bytes(input int a);
    return 2'(((a + 2) % 3) + 1);
  endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_cmd_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic          load_en,
  input  logic [BW-1:0] load_byte,
  output logic          miso,
  output logic          frame_valid,
  output logic [BW-1:0] rx_byte,
  output logic [BW-1:0] shreg_o
);
  localparam int CNT_W = (BW > 1) ? $clog2(BW) : 1;

  logic          sck_d, cs_d;
  logic [BW-1:0] sh_q, sh_d, save_q, save_d, rx_q, rx_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic          full_q, full_d, miso_q, miso_d, fv_q, fv_d;
  logic          sck_rise, sck_fall, cs_fall, cs_rise, whole;

  assign sck_rise = sck & ~sck_d & ~cs_n;
  assign sck_fall = ~sck & sck_d & ~cs_n;
  assign cs_fall  = ~cs_n & cs_d;
  assign cs_rise  = cs_n & ~cs_d;
  assign whole    = full_q && (bit_q == '0);

  always_comb begin
    sh_d   = sh_q;
    save_d = save_q;
    bit_d  = bit_q;
    full_d = full_q;
    miso_d = miso_q;
    fv_d   = 1'b0;
    rx_d   = rx_q;
    if (cs_fall) begin
      save_d = sh_q;
      bit_d  = '0;
      full_d = 1'b0;
    end
    if (sck_rise) begin
      sh_d = {sh_q[BW-2:0], mosi};
      if (bit_q == CNT_W'(BW - 1)) begin
        bit_d  = '0;
        full_d = 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
    if (sck_fall) miso_d = sh_q[BW-1];
    if (cs_n)     miso_d = 1'b0;
    if (cs_rise) begin
      if (whole) begin
        fv_d = 1'b1;
        rx_d = sh_q;
      end else begin
        sh_d = save_q;
      end
    end
    if (load_en) sh_d = load_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b1;
      cs_d   <= 1'b1;
      sh_q   <= '0;
      save_q <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      full_q <= 1'b0;
      miso_q <= 1'b0;
      fv_q   <= 1'b0;
    end else begin
      sck_d  <= sck;
      cs_d   <= cs_n;
      sh_q   <= sh_d;
      save_q <= save_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      full_q <= full_d;
      miso_q <= miso_d;
      fv_q   <= fv_d;
    end
  end

  assign miso        = miso_q;
  assign frame_valid = fv_q;
  assign rx_byte     = rx_q;
  assign shreg_o     = sh_q;
endmodule

// File: rtl/spi_param_regs.sv
module spi_param_regs
  import spi_cmd_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [VAL_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [VAL_W-1:0]          rd_data,
  output logic [NUM_REGS*VAL_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int RW = BYTE_W * int'(reg_bytes(i + 1));
    logic [RW-1:0] val_q, val_d;
    logic          hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(i + 1));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data[RW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_flat[i*VAL_W +: VAL_W] = VAL_W'(val_q);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) rd_data = regs_flat[i*VAL_W +: VAL_W];
    end
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int              NUM_REGS = 6,
  parameter logic [BYTE_W-1:0] DEV_ID = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [VAL_W-1:0]  rd_data,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [VAL_W-1:0]  wr_data,
  output logic [1:0]        rq_cnt
);
  dec_state_e        st_q, st_d;
  logic [1:0]        left_q, left_d, cnt_q, cnt_d, nb;
  logic [ADDR_W-1:0] addr_q, addr_d, a;
  logic [VAL_W-1:0]  acc_q, acc_d, rq_q, rq_d, wdat_q, wdat_d, aligned;
  logic              bad_cmd_q, bad_cmd_d, bad_addr_q, bad_addr_d;
  logic              ld_q, ld_d, wr_q, wr_d;
  logic [BYTE_W-1:0] lb_q, lb_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [2:0]        opc;
  logic              a_ok;

  assign opc     = rx_byte[BYTE_W-1 -: 3];
  assign a       = rx_byte[ADDR_W-1:0];
  assign a_ok    = (a != '0) && (int'(a) <= NUM_REGS);
  assign nb      = reg_bytes(int'(a));
  assign rd_addr = a;
  assign aligned = rd_data << (BYTE_W * (MAX_BYTES - int'(nb)));

  always_comb begin
    st_d       = st_q;
    left_d     = left_q;
    addr_d     = addr_q;
    acc_d      = acc_q;
    rq_d       = rq_q;
    cnt_d      = cnt_q;
    bad_cmd_d  = bad_cmd_q;
    bad_addr_d = bad_addr_q;
    ld_d       = 1'b0;
    lb_d       = '0;
    wr_d       = 1'b0;
    wa_d       = wa_q;
    wdat_d     = wdat_q;
    if (frame_valid) begin
      ld_d = 1'b1;
      if (st_q == DEC_DATA) begin
        acc_d  = {acc_q[VAL_W-BYTE_W-1:0], rx_byte};
        left_d = left_q - 1'b1;
        if (left_q == 2'd1) begin
          st_d   = DEC_CMD;
          wr_d   = 1'b1;
          wa_d   = addr_q;
          wdat_d = acc_d;
        end
      end else if (rx_byte == OP_NOP) begin
        if (cnt_q != 2'd0) begin
          lb_d  = rq_q[VAL_W-1 -: BYTE_W];
          rq_d  = rq_q << BYTE_W;
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        rq_d  = '0;
        cnt_d = 2'd0;
        if (rx_byte == OP_STATUS) begin
          lb_d       = DEV_ID;
          rq_d       = {{(BYTE_W-2){1'b0}}, bad_addr_q, bad_cmd_q,
                        {(VAL_W-BYTE_W){1'b0}}};
          cnt_d      = 2'd1;
          bad_cmd_d  = 1'b0;
          bad_addr_d = 1'b0;
        end else if (opc == GRP_GET && a_ok) begin
          lb_d  = aligned[VAL_W-1 -: BYTE_W];
          rq_d  = aligned << BYTE_W;
          cnt_d = nb - 2'd1;
        end else if (opc == GRP_SET && a_ok) begin
          st_d   = DEC_DATA;
          left_d = nb;
          addr_d = a;
          acc_d  = '0;
        end else if (opc == GRP_GET || opc == GRP_SET) begin
          bad_addr_d = 1'b1;
        end else begin
          bad_cmd_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= DEC_CMD;
      left_q     <= 2'd0;
      addr_q     <= '0;
      acc_q      <= '0;
      rq_q       <= '0;
      cnt_q      <= 2'd0;
      bad_cmd_q  <= 1'b0;
      bad_addr_q <= 1'b0;
      ld_q       <= 1'b0;
      lb_q       <= '0;
      wr_q       <= 1'b0;
      wa_q       <= '0;
      wdat_q     <= '0;
    end else begin
      st_q       <= st_d;
      left_q     <= left_d;
      addr_q     <= addr_d;
      acc_q      <= acc_d;
      rq_q       <= rq_d;
      cnt_q      <= cnt_d;
      bad_cmd_q  <= bad_cmd_d;
      bad_addr_q <= bad_addr_d;
      ld_q       <= ld_d;
      lb_q       <= lb_d;
      wr_q       <= wr_d;
      wa_q       <= wa_d;
      wdat_q     <= wdat_d;
    end
  end

  assign load_en   = ld_q;
  assign load_byte = lb_q;
  assign wr_en     = wr_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wdat_q;
  assign rq_cnt    = cnt_q;
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_cmd_pkg::*;
#(
  parameter int                NUM_REGS = 6,
  parameter logic [BYTE_W-1:0] DEV_ID   = 8'h5A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sck,
  input  logic                      cs_n,
  input  logic                      mosi,
  output logic                      miso,
  output logic [NUM_REGS*VAL_W-1:0] param_regs
);
  logic              frame_valid, load_en, wr_en;
  logic [BYTE_W-1:0] rx_byte, load_byte, shreg;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [VAL_W-1:0]  rd_data, wr_data;
  logic [1:0]        rq_cnt;

  spi_byte_shifter #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .load_en(load_en), .load_byte(load_byte), .miso(miso),
    .frame_valid(frame_valid), .rx_byte(rx_byte), .shreg_o(shreg)
  );

  spi_cmd_decoder #(.NUM_REGS(NUM_REGS), .DEV_ID(DEV_ID)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .rx_byte(rx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .load_en(load_en),
    .load_byte(load_byte), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rq_cnt(rq_cnt)
  );

  spi_param_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(param_regs)
  );
endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk
  import spi_cmd_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              cs_n,
  input logic              mosi,
  input logic              miso,
  input logic [BYTE_W-1:0] shreg,
  input logic              frame_valid,
  input logic              load_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        rq_cnt
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && !$past(sck)) |=>
      (shreg == {$past(shreg[BYTE_W-2:0]), $past(mosi)}));

  p_miso_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !miso);

  p_frame_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ($past(cs_n) && !$past(cs_n, 2)));

  p_load_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> $past(frame_valid));

  p_write_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_addr != '0) && (int'(wr_addr) <= NUM_REGS)));

  p_reply_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rq_cnt <= 2'd2);

  p_no_frame_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> !frame_valid);
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .miso(miso), .shreg(shreg), .frame_valid(frame_valid),
  .load_en(load_en), .wr_en(wr_en), .wr_addr(wr_addr), .rq_cnt(rq_cnt)
);

// File: tb/spi_chain_slave_test.sv
module spi_chain_slave_test;
  localparam int NUM    = 6;
  localparam int HALF   = 4;
  localparam logic [7:0] DEV = 8'h5A;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi;
  logic miso;
  logic [NUM*24-1:0] param_regs;

  always #5 clk = ~clk;

  spi_chain_slave #(.NUM_REGS(NUM), .DEV_ID(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .param_regs(param_regs)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference model
  logic [7:0]  m_held;
  logic [7:0]  rq[$];
  int          m_regs[1:NUM];
  bit          m_in_set, m_bad_cmd, m_bad_addr;
  int          m_left, m_addr, m_acc;
  logic [7:0]  tx[$];
  logic [7:0]  got[$];

  function automatic int nbytes(input int a);
    return ((a + 2) % 3) + 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_decode(input logic [7:0] b);
    int a, n;
    a = int'(b[4:0]);
    if (m_in_set) begin
      m_acc = (m_acc << 8) | int'(b);
      m_left--;
      if (m_left == 0) begin
        m_regs[m_addr] = m_acc;
        m_in_set = 1'b0;
      end
      m_held = 8'h00;
    end else if (b == 8'h00) begin
      m_held = (rq.size() > 0) ? rq.pop_front() : 8'h00;
    end else begin
      rq.delete();
      m_held = 8'h00;
      if (b == 8'hD0) begin
        m_held = DEV;
        rq.push_back({6'b0, m_bad_addr, m_bad_cmd});
        m_bad_cmd  = 1'b0;
        m_bad_addr = 1'b0;
      end else if (b[7:6] == 2'b00) begin
        if (a >= 1 && a <= NUM) begin
          n = nbytes(a);
          if (b[5]) begin
            for (int k = n - 1; k >= 0; k--) rq.push_back(8'((m_regs[a] >> (8 * k)) & 255));
            m_held = rq.pop_front();
          end else begin
            m_in_set = 1'b1;
            m_left   = n;
            m_addr   = a;
            m_acc    = 0;
          end
        end else begin
          m_bad_addr = 1'b1;
        end
      end else begin
        m_bad_cmd = 1'b1;
      end
    end
  endtask

  task automatic shift_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      sck  = 1'b0;
      mosi = b[i];
      tick(HALF);
      r[i] = miso;
      sck  = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int i = 1; i <= NUM; i++)
      check(tag, int'(param_regs[(i-1)*24 +: 24]), m_regs[i]);
  endtask

  // whole-byte frame from tx; checks every MISO byte and decode result
  task automatic run_frame(input string tag, input int gap);
    logic [7:0] r;
    logic [7:0] exp_q[$];
    exp_q.push_back(m_held);
    for (int k = 0; k < tx.size() - 1; k++) exp_q.push_back(tx[k]);
    cs_n = 1'b0;
    tick(HALF);
    got.delete();
    for (int k = 0; k < tx.size(); k++) begin
      shift_bits(tx[k], 8, r);
      got.push_back(r);
    end
    cs_n = 1'b1;
    tick(gap);
    for (int k = 0; k < exp_q.size(); k++) check(tag, int'(got[k]), int'(exp_q[k]));
    model_decode(tx[tx.size()-1]);
    check_regs(tag);
    tx.delete();
  endtask

  task automatic partial_frame(input int nbits);
    logic [7:0] r;
    cs_n = 1'b0;
    tick(HALF);
    for (int left = nbits; left > 0; left -= 8)
      shift_bits(8'hA7, (left > 8) ? 8 : left, r);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic one(input logic [7:0] b, input string tag);
    tx.push_back(b);
    run_frame(tag, 6);
  endtask

  // R4: MISO low once chip select has been high for two cycles
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n || !cs_n) hi_cnt <= 0;
    else begin
      hi_cnt <= hi_cnt + 1;
      if (hi_cnt >= 2) check("R4 miso idle", int'(miso), 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sck = 1'b1; cs_n = 1'b1; mosi = 1'b0;
    m_held = 8'h00; m_in_set = 0; m_bad_cmd = 0; m_bad_addr = 0;
    m_left = 0; m_addr = 0; m_acc = 0;
    for (int i = 1; i <= NUM; i++) m_regs[i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    check("R12 reset miso", int'(miso), 0);
    check_regs("R12 reset regs");

    one(8'h00, "R12/R5 nop after reset");
    tx = '{8'hD0, 8'h55, 8'h00};
    run_frame("R1/R2 delay line", 6);

    one(8'hD0, "R6 status cmd");
    one(8'h00, "R6 status high byte");
    one(8'h00, "R6 status low byte");
    one(8'h00, "R5 nop empty");

    one(8'hFF, "R11 bad cmd");
    one(8'hD0, "R11 status read");
    one(8'h00, "R11 flag bad_cmd");
    one(8'h20, "R11 addr zero");
    one(8'h27, "R11 addr high");
    one(8'hD0, "R11 status again");
    one(8'h00, "R11 flag bad_addr");
    one(8'h00, "R6 flags cleared");
    one(8'hD0, "R6 status reread");
    one(8'h00, "R6 reread high");
    one(8'h00, "R6 reread low");

    one(8'h01, "R8 set p1");
    one(8'hD0, "R8 data not command");
    one(8'h02, "R8 set p2");
    one(8'h12, "R8 p2 byte1");
    one(8'h34, "R8 p2 byte2");
    one(8'h03, "R8 set p3");
    one(8'hDE, "R8 p3 byte1");
    one(8'hAD, "R8 p3 byte2");
    one(8'hBE, "R8 p3 byte3");
    one(8'h06, "R8 set p6");
    one(8'h00, "R8 nop as data");
    one(8'h11, "R8 p6 byte2");
    one(8'h77, "R8 p6 byte3");

    one(8'h23, "R7 get p3");
    one(8'h00, "R7 p3 next");
    one(8'h00, "R7 p3 last");
    one(8'h00, "R7 p3 drained");
    one(8'h21, "R7 get p1");
    one(8'h00, "R7 p1 drained");

    one(8'h23, "R10 get p3");
    one(8'h00, "R10 first nop");
    one(8'h22, "R10 new get flushes");
    one(8'h00, "R10 p2 low");
    one(8'h00, "R10 nothing left");

    one(8'h23, "R9 get before partial");
    partial_frame(5);
    one(8'h00, "R9 held kept after 5 bits");
    partial_frame(12);
    one(8'h00, "R9 held kept after 12 bits");
    partial_frame(0);
    one(8'h00, "R9 empty select pulse");

    tx = '{8'h00, 8'h26};
    run_frame("R2 chain last byte decoded", 6);
    tx = '{8'h00, 8'h00, 8'h00};
    run_frame("R2 chain three bytes", 6);
    one(8'h00, "R2 chain pop");

    tx.push_back(8'h25);
    run_frame("R3 short gap get", 4);
    tx.push_back(8'h00);
    run_frame("R3 short gap reply", 4);
    one(8'h00, "R3 short gap last");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule